// File: doc/BRIEF.md
# Locked Split-Byte Result Register

This block keeps the latest 10-bit sample from a converter and shows it to an 8-bit bus as two bytes. A configuration bit selects the layout. With the bit clear, the value sits at the bottom of the 16-bit pair. With the bit set, it is pushed to the top, so that software needing only 8 bits can read the high byte alone. A stored value of zero stands for ground. A stored value of all ones stands for the reference level minus one LSB.

Software reading both bytes reads the low byte first. That read locks the stored value, so that both bytes come from the same sample. The matching read of the high byte releases the lock. A sample that arrives while the lock is held is dropped, and a one-cycle lost pulse marks it. The completion interrupt pulse fires for every sample, kept or dropped.

Top module: `split_result_reg`

## Requirements
- R1: After reset the stored value is zero and the lock is released. `lo_byte_o`, `hi_byte_o`, `irq_o` and `lost_o` are all 0.
- R2: With `left_just_i`=0, `hi_byte_o` = {6'b0, value[9:8]} and `lo_byte_o` = value[7:0].
- R3: With `left_just_i`=1, `hi_byte_o` = value[9:2] and `lo_byte_o` = {value[1:0], 6'b0}.
- R4: `left_just_i` affects only the byte views, and a change shows in the same cycle. Toggling it never changes the stored value.
- R5: A cycle with `rd_lo_i`=1 engages the lock. While the lock is held, a `res_valid_i` strobe leaves both bytes unchanged.
- R6: A cycle with `rd_hi_i`=1 releases the lock, and the next strobe is stored.
- R7: `lost_o` is high for exactly the one cycle after each strobe that arrives while the lock is held. It stays low after a strobe that is stored.
- R8: `irq_o` is high for the one cycle after every `res_valid_i` strobe, whether the sample was stored or dropped.
- R9: A high-byte read with no preceding low-byte read leaves the lock released.
- R10: A byte read in the same cycle as a strobe returns the value held before that cycle. Whether the strobe is stored depends on the lock state held before that cycle, not on the read made in the same cycle.
- R11: When `rd_lo_i` and `rd_hi_i` are high in the same cycle, the lock ends released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| res_valid_i | input | 1 | One-cycle strobe: a new sample is present on `res_data_i` |
| res_data_i | input | 10 | Sample value |
| left_just_i | input | 1 | 1: left-justified layout, 0: right-justified layout |
| rd_lo_i | input | 1 | Low-byte read strobe |
| rd_hi_i | input | 1 | High-byte read strobe |
| lo_byte_o | output | 8 | Low byte view |
| hi_byte_o | output | 8 | High byte view |
| lost_o | output | 1 | Pulse: the previous cycle's sample was dropped |
| irq_o | output | 1 | Pulse: the previous cycle completed a conversion |

## Verification
Samples with alternating bit patterns (0x2A5, 0x155, 0x2AA) are viewed in both layouts. A wrong bit slice in either layout then shows as a wrong byte. An all-ones-heavy value (0x3C3) checks the two spill bits and the zero padding.

The lock is driven with three kinds of read sequence: low byte then high byte, high byte alone, and both strobes in one cycle. Each sequence tells a properly released lock from one left stuck. Strobes are also placed in the same cycle as a low-byte read and as a high-byte read. These cases separate a design that decides from the lock state held before the cycle from one that uses the read made in that cycle.

// File: rtl/split_result_pkg.sv
package split_result_pkg;
  parameter int unsigned RES_W  = 10;
  parameter int unsigned BYTE_W = 8;

  typedef logic [RES_W-1:0]  res_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic {
    JUST_RIGHT = 1'b0,
    JUST_LEFT  = 1'b1
  } just_e;
endpackage

// File: rtl/srr_lock_ctrl.sv
module srr_lock_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic res_valid_i,
  input  logic rd_lo_i,
  input  logic rd_hi_i,
  output logic lock_o,
  output logic accept_o,
  output logic lost_o,
  output logic irq_o
);
  logic lock_q, lock_d;
  logic lost_q, irq_q;

  // accept/drop decided on the lock held before this cycle
  assign accept_o = res_valid_i & ~lock_q;

  always_comb begin
    lock_d = lock_q;
    if (rd_lo_i) lock_d = 1'b1;
    if (rd_hi_i) lock_d = 1'b0;  // high read wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      lost_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      lock_q <= lock_d;
      lost_q <= res_valid_i & lock_q;
      irq_q  <= res_valid_i;
    end
  end

  assign lock_o = lock_q;
  assign lost_o = lost_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/srr_store.sv
module srr_store
  import split_result_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  res_t data_i,
  output res_t data_o
);
  res_t data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_q <= '0;
    else if (wr_i) data_q <= data_i;
  end

  assign data_o = data_q;
endmodule

// File: rtl/srr_view.sv
module srr_view
  import split_result_pkg::*;
(
  input  res_t  data_i,
  input  logic  left_just_i,
  output byte_t lo_o,
  output byte_t hi_o
);
  localparam int unsigned SPILL_W = RES_W - BYTE_W;
  localparam int unsigned PAD_W   = BYTE_W - SPILL_W;

  byte_t lo_r, hi_r, lo_l, hi_l;

  generate
    if (PAD_W == 0) begin : g_full
      assign hi_r = data_i[RES_W-1:BYTE_W];
      assign lo_l = data_i[SPILL_W-1:0];
    end else begin : g_pad
      assign hi_r = {{PAD_W{1'b0}}, data_i[RES_W-1:BYTE_W]};
      assign lo_l = {data_i[SPILL_W-1:0], {PAD_W{1'b0}}};
    end
  endgenerate

  assign lo_r = data_i[BYTE_W-1:0];
  assign hi_l = data_i[RES_W-1 -: BYTE_W];

  always_comb begin
    if (just_e'(left_just_i) == JUST_LEFT) begin
      lo_o = lo_l;
      hi_o = hi_l;
    end else begin
      lo_o = lo_r;
      hi_o = hi_r;
    end
  end
endmodule

// File: rtl/split_result_reg.sv
module split_result_reg
  import split_result_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        res_valid_i,
  input  logic [9:0]  res_data_i,
  input  logic        left_just_i,
  input  logic        rd_lo_i,
  input  logic        rd_hi_i,
  output logic [7:0]  lo_byte_o,
  output logic [7:0]  hi_byte_o,
  output logic        lost_o,
  output logic        irq_o
);
  logic lock_q, accept;
  res_t data_q;

  srr_lock_ctrl u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .res_valid_i (res_valid_i),
    .rd_lo_i     (rd_lo_i),
    .rd_hi_i     (rd_hi_i),
    .lock_o      (lock_q),
    .accept_o    (accept),
    .lost_o      (lost_o),
    .irq_o       (irq_o)
  );

  srr_store u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (accept),
    .data_i (res_data_i),
    .data_o (data_q)
  );

  srr_view u_view (
    .data_i      (data_q),
    .left_just_i (left_just_i),
    .lo_o        (lo_byte_o),
    .hi_o        (hi_byte_o)
  );
endmodule

// File: rtl/split_result_reg_chk.sv
module split_result_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       res_valid_i,
  input logic       rd_lo_i,
  input logic       rd_hi_i,
  input logic       lock_q,
  input logic [9:0] data_q,
  input logic       lost_o,
  input logic       irq_o
);
  // R5
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(data_q));

  // R5
  lo_read_locks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i && !rd_hi_i |=> lock_q);

  // R6
  hi_read_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi_i |=> !lock_q);

  // R7
  drop_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && lock_q |=> lost_o);

  // R7
  no_spurious_lost_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_valid_i && lock_q) |=> !lost_o);

  // R8
  irq_every_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> irq_o);

  // R8
  irq_only_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> !irq_o);
endmodule

bind split_result_reg split_result_reg_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .res_valid_i (res_valid_i),
  .rd_lo_i     (rd_lo_i),
  .rd_hi_i     (rd_hi_i),
  .lock_q      (lock_q),
  .data_q      (data_q),
  .lost_o      (lost_o),
  .irq_o       (irq_o)
);

// File: tb/split_result_reg_bench.sv
module split_result_reg_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       res_valid_i = 1'b0;
  logic [9:0] res_data_i = '0;
  logic       left_just_i = 1'b0;
  logic       rd_lo_i = 1'b0;
  logic       rd_hi_i = 1'b0;
  logic [7:0] lo_byte_o, hi_byte_o;
  logic       lost_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  split_result_reg u_split_result_reg (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic views(input string req, input int hi, input int lo);
    chk(req, hi_byte_o, hi);
    chk(req, lo_byte_o, lo);
  endtask

  // drive one strobe; report the flags seen after the edge
  task automatic push(input logic [9:0] d, output logic irq, output logic lost);
    @(negedge clk_i);
    res_valid_i = 1'b1;
    res_data_i  = d;
    @(negedge clk_i);
    irq = irq_o;
    lost = lost_o;
    res_valid_i = 1'b0;
  endtask

  task automatic rd_lo(output int v);
    @(negedge clk_i);
    rd_lo_i = 1'b1;
    v = lo_byte_o;
    @(negedge clk_i);
    rd_lo_i = 1'b0;
  endtask

  task automatic rd_hi(output int v);
    @(negedge clk_i);
    rd_hi_i = 1'b1;
    v = hi_byte_o;
    @(negedge clk_i);
    rd_hi_i = 1'b0;
  endtask

  task automatic t_reset();
    views("R1 reset", 0, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 lost", lost_o, 0);
  endtask

  task automatic t_layout();
    logic irq, lost;
    left_just_i = 1'b0;
    push(10'h2A5, irq, lost);
    views("R2 right 0x2A5", 8'h02, 8'hA5);
    chk("R8 irq", irq, 1);
    chk("R7 no lost", lost, 0);
    push(10'h3FF, irq, lost);
    views("R2 right 0x3FF", 8'h03, 8'hFF);
    push(10'h2A5, irq, lost);
    left_just_i = 1'b1;
    #1 views("R3 left 0x2A5", 8'hA9, 8'h40);
    left_just_i = 1'b0;
    #1 views("R4 back to right", 8'h02, 8'hA5);
    @(negedge clk_i);
    chk("R8 irq clears", irq_o, 0);
  endtask

  task automatic t_lock();
    logic irq, lost;
    int v;
    left_just_i = 1'b0;
    push(10'h155, irq, lost);
    rd_lo(v);
    chk("R5 low read", v, 8'h55);
    push(10'h2AA, irq, lost);
    chk("R8 irq on drop", irq, 1);
    chk("R7 lost on drop", lost, 1);
    views("R5 frozen", 8'h01, 8'h55);
    @(negedge clk_i);
    chk("R7 lost one cycle", lost_o, 0);
    rd_hi(v);
    chk("R6 high read", v, 8'h01);
    push(10'h2AA, irq, lost);
    chk("R7 accepted no lost", lost, 0);
    views("R6 updated", 8'h02, 8'hAA);
  endtask

  task automatic t_hi_only();
    logic irq, lost;
    int v;
    left_just_i = 1'b1;
    rd_hi(v);
    chk("R9 hi-only read", v, 8'hAA);
    push(10'h3C3, irq, lost);
    chk("R9 no lost", lost, 0);
    views("R9 updated", 8'hF0, 8'hC0);
  endtask

  task automatic t_same_cycle();
    logic irq, lost;
    int v;
    left_just_i = 1'b0;
    #1 views("R4 stored kept", 8'h03, 8'hC3);
    @(negedge clk_i);
    rd_lo_i = 1'b1;
    res_valid_i = 1'b1;
    res_data_i = 10'h0F0;
    v = lo_byte_o;
    @(negedge clk_i);
    chk("R10 read returns old", v, 8'hC3);
    chk("R10 unlocked strobe kept", lost_o, 0);
    rd_lo_i = 1'b0;
    res_valid_i = 1'b0;
    views("R10 new value stored", 8'h00, 8'hF0);
    push(10'h111, irq, lost);
    chk("R10 lock engaged", lost, 1);
    views("R5 frozen again", 8'h00, 8'hF0);
    @(negedge clk_i);
    rd_hi_i = 1'b1;
    res_valid_i = 1'b1;
    res_data_i = 10'h222;
    v = hi_byte_o;
    @(negedge clk_i);
    chk("R10 hi read old", v, 8'h00);
    chk("R10 locked strobe dropped", lost_o, 1);
    chk("R8 irq on drop", irq_o, 1);
    rd_hi_i = 1'b0;
    res_valid_i = 1'b0;
    views("R10 drop kept bytes", 8'h00, 8'hF0);
    push(10'h333, irq, lost);
    chk("R6 released", lost, 0);
    views("R6 after release", 8'h03, 8'h33);
  endtask

  task automatic t_both();
    logic irq, lost;
    @(negedge clk_i);
    rd_lo_i = 1'b1;
    rd_hi_i = 1'b1;
    @(negedge clk_i);
    rd_lo_i = 1'b0;
    rd_hi_i = 1'b0;
    push(10'h1E7, irq, lost);
    chk("R11 both reads release", lost, 0);
    views("R11 updated", 8'h01, 8'hE7);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #35 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_layout();
    t_lock();
    t_hi_only();
    t_same_cycle();
    t_both();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule